// File: doc/BRIEF.md
# Periodic-Tick Real-Time Clock

This block is a small real-time clock that the host reaches through two byte-wide I/O ports. A write to the index port chooses one of the clock's internal registers. A later read or write on the data port then reaches that register. The registers are seconds, minutes, hours, day of week, day of month, month, year and four control registers. Host accesses are single-cycle strobes. A read returns its byte one cycle later, marked by a valid strobe. A data-port access to an index the block does not know returns an error strobe instead.

A free-running divider raises a one-cycle periodic interrupt every `PERIOD_CYCLES` clock cycles. The block also counts these pulses modulo `PULSES_PER_SEC` (1024 by default). Each time that count wraps, the seconds field advances by one and goes from 59 back to 0. No other calendar field advances by itself. The month is held internally zero-based but is shown one-based. The year is held with a bias of `YEAR_BIAS` (52) added to the value the host writes.

Each host access is tracked by a four-state response machine:
- **IDLE**: no response is pending.
- **RDATA**: read data is presented on `io_rdata` with `io_rvalid`.
- **WACK**: a write has been accepted. Nothing is signalled.
- **FAULT**: `io_err` is raised.

The machine enters RDATA, WACK or FAULT from any state in the cycle after a request that calls for it. It returns to IDLE when no request is present. Back-to-back requests move it straight from one response state to the next.

Top module: `rtc_tick_clock`

## Requirements
- R1: A write to the index port (`INDEX_PORT`, 0x70) stores `io_wdata` as the selected index. It raises neither `io_rvalid` nor `io_err`. A read of the index port returns the stored index with `io_rvalid` one cycle after the request.
- R2: `rtc_irq` is a one-cycle pulse. After reset is released, the first pulse appears after `PERIOD_CYCLES` clock edges, and the next pulses follow every `PERIOD_CYCLES` edges (`PERIOD_CYCLES` ≥ 2).
- R3: The periodic pulses are counted modulo `PULSES_PER_SEC`. On the pulse that completes each group (pulses 1024, 2048, … since reset), seconds advance by one. The value 59 advances to 0.
- R4: Seconds change by themselves only at the edge that raises the completing `rtc_irq` pulse. Before that pulse they hold the value they had.
- R5: Index codes 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x06 (day of week) and 0x07 (day of month) read back exactly the byte last written to them through the data port.
- R6: Index 0x08 (month) stores the written value minus 1 and reads as the stored value plus 1. A written month therefore reads back unchanged, and after reset it reads 1.
- R7: Index 0x09 (year) stores the written value plus `YEAR_BIAS` (52) and reads as the stored value minus 52, modulo 256. A written year therefore reads back unchanged, and after reset it reads 204.
- R8: Index codes 0x0A–0x0D (control A–D) accept writes without error, and those writes change nothing. Reads of these codes return 0 with `io_rvalid`.
- R9: A data-port read or write under any other index raises `io_err` for one cycle, one cycle after the request. It raises no `io_rvalid` and changes no field.
- R10: When a data-port write to seconds falls in the same cycle as a seconds advance, the written value is stored and the advance is lost.
- R11: During and right after reset, `io_rvalid`, `io_err`, `rtc_irq` and `io_rdata` are 0. The divider, the pulse count, the index and all stored fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W | I/O port address of the current request |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access (wins over io_rd) |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, meaningful while io_rvalid is high |
| io_rvalid | output | 1 | Read response strobe |
| io_err | output | 1 | Unknown-index data access strobe |
| rtc_irq | output | 1 | Periodic interrupt pulse |

## Verification
The two functions that can fall in the same cycle are the host's write to seconds and the automatic seconds advance at the end of each 1024-pulse group. The bench counts interrupt pulses from reset. It times a data-port write to seconds so that the write is sampled on exactly the edge that raises pulse 2048. It then reads back the written value, not the written value plus one. One group later it checks that the count goes on from that value. The wrap from 59 to 0 is judged the same way. Seconds are read one pulse before the group boundary and again right after it.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    localparam int BYTE_W = 8;

    // Register index codes; the host software depends on these values
    localparam logic [BYTE_W-1:0] IDX_SEC   = 8'h00;
    localparam logic [BYTE_W-1:0] IDX_MIN   = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_HOUR  = 8'h04;
    localparam logic [BYTE_W-1:0] IDX_WDAY  = 8'h06;
    localparam logic [BYTE_W-1:0] IDX_MDAY  = 8'h07;
    localparam logic [BYTE_W-1:0] IDX_MON   = 8'h08;
    localparam logic [BYTE_W-1:0] IDX_YEAR  = 8'h09;
    localparam logic [BYTE_W-1:0] IDX_CTL_A = 8'h0A;
    localparam logic [BYTE_W-1:0] IDX_CTL_D = 8'h0D;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_RDATA = 2'd1,
        ACC_WACK  = 2'd2,
        ACC_FAULT = 2'd3
    } acc_state_t;

    function automatic logic idx_is_ctl(input logic [BYTE_W-1:0] idx);
        return (idx >= IDX_CTL_A) && (idx <= IDX_CTL_D);
    endfunction

    function automatic logic idx_is_known(input logic [BYTE_W-1:0] idx);
        return (idx == IDX_SEC) || (idx == IDX_MIN) || (idx == IDX_HOUR) ||
               (idx == IDX_WDAY) || (idx == IDX_MDAY) || (idx == IDX_MON) ||
               (idx == IDX_YEAR) || idx_is_ctl(idx);
    endfunction

endpackage

// File: rtl/rtc_pulse_div.sv
module rtc_pulse_div #(
    parameter int PERIOD_CYCLES  = 32,
    parameter int PULSES_PER_SEC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic irq_q,
    output logic sec_adv
);
    localparam int CW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam int PW = (PULSES_PER_SEC > 1) ? $clog2(PULSES_PER_SEC) : 1;
    localparam logic [CW-1:0] CYC_LAST   = CW'(PERIOD_CYCLES - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSES_PER_SEC - 1);
    localparam bit PULSE_POW2 = ((1 << PW) == PULSES_PER_SEC);

    logic [CW-1:0] cyc_q;
    logic [PW-1:0] pulse_q;
    logic          tick;

    assign tick    = (cyc_q == CYC_LAST);
    assign sec_adv = tick && (pulse_q == PULSE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cyc_q <= tick ? '0 : cyc_q + 1'b1;
            irq_q <= tick;
        end
    end

    generate
        if (PULSE_POW2) begin : g_pulse_wrap_free
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    pulse_q <= '0;
                else if (tick) pulse_q <= pulse_q + 1'b1;
            end
        end else begin : g_pulse_wrap_cmp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    pulse_q <= '0;
                else if (tick) pulse_q <= (pulse_q == PULSE_LAST) ? '0 : pulse_q + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_tick_pkg::*;
#(
    parameter int YEAR_BIAS = 52,
    parameter int SEC_WRAP  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              sec_adv,
    input  logic [BYTE_W-1:0] rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [BYTE_W-1:0] BIAS     = BYTE_W'(YEAR_BIAS);
    localparam logic [BYTE_W-1:0] SEC_LAST = BYTE_W'(SEC_WRAP - 1);

    logic [BYTE_W-1:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;

    // Seconds: a host write takes precedence over the periodic advance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sec_q <= '0;
        else if (wr_en && (wr_idx == IDX_SEC))
            sec_q <= wr_data;
        else if (sec_adv)
            sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q  <= '0;
            hour_q <= '0;
            wday_q <= '0;
            mday_q <= '0;
            mon_q  <= '0;
            year_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_MIN:  min_q  <= wr_data;
                IDX_HOUR: hour_q <= wr_data;
                IDX_WDAY: wday_q <= wr_data;
                IDX_MDAY: mday_q <= wr_data;
                IDX_MON:  mon_q  <= wr_data - 1'b1;
                IDX_YEAR: year_q <= wr_data + BIAS;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_SEC:  rd_data = sec_q;
            IDX_MIN:  rd_data = min_q;
            IDX_HOUR: rd_data = hour_q;
            IDX_WDAY: rd_data = wday_q;
            IDX_MDAY: rd_data = mday_q;
            IDX_MON:  rd_data = mon_q + 1'b1;
            IDX_YEAR: rd_data = year_q - BIAS;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_access_fsm.sv
module rtc_access_fsm
    import rtc_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic       hit_index,
    input  logic       hit_data,
    input  logic       idx_known,
    output acc_state_t state_q,
    output logic       index_we,
    output logic       data_we,
    output logic       rd_capture,
    output logic       rvalid,
    output logic       err
);
    acc_state_t state_d;
    logic       rd_req;

    assign rd_req     = io_rd && !io_wr;
    assign index_we   = io_wr && hit_index;
    assign data_we    = io_wr && hit_data && idx_known;
    assign rd_capture = rd_req && (hit_index || (hit_data && idx_known));

    always_comb begin
        state_d = ACC_IDLE;
        if (io_wr && hit_data)
            state_d = idx_known ? ACC_WACK : ACC_FAULT;
        else if (index_we)
            state_d = ACC_WACK;
        else if (rd_req && hit_data)
            state_d = idx_known ? ACC_RDATA : ACC_FAULT;
        else if (rd_req && hit_index)
            state_d = ACC_RDATA;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_RDATA: rvalid = 1'b1;
            ACC_WACK:  ;
            ACC_FAULT: err = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_tick_clock.sv
module rtc_tick_clock
    import rtc_tick_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int INDEX_PORT     = 'h70,
    parameter int DATA_PORT      = 'h71,
    parameter int PERIOD_CYCLES  = 32,
    parameter int PULSES_PER_SEC = 1024,
    parameter int YEAR_BIAS      = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    output logic              io_err,
    output logic              rtc_irq
);
    logic              hit_index, hit_data;
    logic              index_we, data_we, rd_capture;
    logic              sec_adv;
    logic [BYTE_W-1:0] index_q, rdata_q, field_rd;
    acc_state_t        acc_state;

    assign hit_index = (io_addr == ADDR_W'(INDEX_PORT));
    assign hit_data  = (io_addr == ADDR_W'(DATA_PORT));

    rtc_pulse_div #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .PULSES_PER_SEC(PULSES_PER_SEC)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_q  (rtc_irq),
        .sec_adv(sec_adv)
    );

    rtc_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .hit_index (hit_index),
        .hit_data  (hit_data),
        .idx_known (idx_is_known(index_q)),
        .state_q   (acc_state),
        .index_we  (index_we),
        .data_we   (data_we),
        .rd_capture(rd_capture),
        .rvalid    (io_rvalid),
        .err       (io_err)
    );

    rtc_time_regs #(
        .YEAR_BIAS(YEAR_BIAS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (data_we),
        .wr_idx (index_q),
        .wr_data(io_wdata),
        .sec_adv(sec_adv),
        .rd_idx (index_q),
        .rd_data(field_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            rdata_q <= '0;
        end else begin
            if (index_we)
                index_q <= io_wdata;
            if (rd_capture)
                rdata_q <= hit_index ? index_q : field_rd;
        end
    end

    assign io_rdata = rdata_q;

endmodule

// File: rtl/rtc_tick_clock_chk.sv
module rtc_tick_clock_chk #(
    parameter int ADDR_W     = 8,
    parameter int INDEX_PORT = 'h70
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              io_rvalid,
    input logic              io_err,
    input logic              rtc_irq,
    input logic              sec_adv
);
    p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_irq |=> !rtc_irq);

    p_adv_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_adv |=> rtc_irq);

    p_resp_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rvalid && io_err));

    p_rvalid_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> $past(io_rd && !io_wr));

    p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_err |-> $past(io_rd || io_wr));

    p_index_write_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == ADDR_W'(INDEX_PORT))) |=> (!io_err && !io_rvalid));

endmodule

bind rtc_tick_clock rtc_tick_clock_chk #(
    .ADDR_W    (ADDR_W),
    .INDEX_PORT(INDEX_PORT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rvalid(io_rvalid),
    .io_err   (io_err),
    .rtc_irq  (rtc_irq),
    .sec_adv  (sec_adv)
);

// File: tb/rtc_tick_clock_tb_top.sv
`timescale 1ns/1ps
module rtc_tick_clock_tb_top;
    localparam int P  = 2;
    localparam int PG = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       io_rvalid, io_err, rtc_irq;

    int checks = 0, errors = 0, irq_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_tick_clock #(.PERIOD_CYCLES(P), .PULSES_PER_SEC(PG)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .io_err(io_err), .rtc_irq(rtc_irq));

    always @(negedge clk) if (rst_n && rtc_irq) irq_seen <= irq_seen + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One access; returns the response seen one cycle later
    task automatic bus(input logic [7:0] a, input bit rd, input bit wr, input logic [7:0] d,
                       output logic rv, output logic er, output logic [7:0] q);
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
        @(negedge clk); #1;
        io_rd = 1'b0; io_wr = 1'b0;
        rv = io_rvalid; er = io_err; q = io_rdata;
    endtask

    task automatic set_index(input logic [7:0] idx, input string req);
        logic rv, er; logic [7:0] q;
        bus(8'h70, 0, 1, idx, rv, er, q);
        check(req, {rv, er}, 0);
    endtask

    task automatic put(input logic [7:0] idx, input logic [7:0] v, input string req);
        logic rv, er; logic [7:0] q;
        set_index(idx, req);
        bus(8'h71, 0, 1, v, rv, er, q);
        check(req, {rv, er}, 0);
    endtask

    task automatic get(input logic [7:0] idx, input logic [7:0] exp, input string req);
        logic rv, er; logic [7:0] q;
        set_index(idx, req);
        bus(8'h71, 1, 0, 8'h00, rv, er, q);
        check(req, {rv, er, q}, {2'b10, exp});
    endtask

    task automatic wait_irq(input int n);
        while (irq_seen < n) begin @(negedge clk); #1; end
    endtask

    task automatic t_reset;
        check("R11 outputs in reset", {io_rvalid, io_err, rtc_irq, io_rdata}, 0);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R11 outputs after reset", {io_rvalid, io_err, rtc_irq, io_rdata}, 0);
        get(8'h00, 8'h00, "R11 seconds zero");
        get(8'h08, 8'h01, "R6 month reset reads 1");
        get(8'h09, 8'd204, "R7 year reset reads 204");
    endtask

    task automatic t_tick;
        int gap = 0;
        while (!rtc_irq) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        check("R2 pulse one cycle", rtc_irq, 0);
        gap = 1;
        while (!rtc_irq) begin @(negedge clk); #1; gap++; end
        check("R2 pulse spacing", gap, P);
    endtask

    task automatic t_plain;
        put(8'h02, 8'h2A, "R5"); put(8'h04, 8'h17, "R5");
        put(8'h06, 8'h03, "R5"); put(8'h07, 8'h1F, "R5");
        get(8'h02, 8'h2A, "R5 minutes"); get(8'h04, 8'h17, "R5 hours");
        get(8'h06, 8'h03, "R5 day of week"); get(8'h07, 8'h1F, "R5 day of month");
    endtask

    task automatic t_offsets;
        put(8'h08, 8'd12, "R6"); get(8'h08, 8'd12, "R6 month round trip");
        put(8'h08, 8'd1, "R6");  get(8'h08, 8'd1, "R6 month one");
        put(8'h09, 8'd99, "R7"); get(8'h09, 8'd99, "R7 year round trip");
        put(8'h09, 8'd250, "R7"); get(8'h09, 8'd250, "R7 year wrap");
    endtask

    task automatic t_ctrl;
        for (int i = 10; i <= 13; i++) begin
            put(8'(i), 8'hFF, "R8 control write");
            get(8'(i), 8'h00, "R8 control reads zero");
        end
        get(8'h02, 8'h2A, "R8 minutes untouched");
        get(8'h08, 8'd1, "R8 month untouched");
    endtask

    task automatic t_bad_index;
        logic rv, er; logic [7:0] q;
        set_index(8'h33, "R9");
        bus(8'h71, 0, 1, 8'h77, rv, er, q);
        check("R9 write error", {rv, er}, 2'b01);
        bus(8'h71, 1, 0, 8'h00, rv, er, q);
        check("R9 read error", {rv, er}, 2'b01);
        @(negedge clk); #1;
        check("R9 error one cycle", io_err, 0);
        bus(8'h70, 1, 0, 8'h00, rv, er, q);
        check("R1 index readback", {rv, er, q}, {2'b10, 8'h33});
        get(8'h02, 8'h2A, "R9 minutes untouched");
        get(8'h00, 8'h00, "R9 seconds untouched");
    endtask

    task automatic t_seconds;
        logic rv, er; logic [7:0] q;
        put(8'h00, 8'd59, "R3");
        wait_irq(PG - 1);
        get(8'h00, 8'd59, "R4 no advance before group end");
        wait_irq(PG);
        get(8'h00, 8'd0, "R3 59 wraps to 0");
        // R10: write seconds on the edge that raises pulse 2*PG
        set_index(8'h00, "R10");
        wait_irq(2 * PG - 1);
        repeat (P - 1) @(negedge clk);
        #1;
        bus(8'h71, 0, 1, 8'd21, rv, er, q);
        check("R10 advance edge reached", irq_seen, 2 * PG);
        get(8'h00, 8'd21, "R10 write wins over advance");
        wait_irq(3 * PG - 1);
        get(8'h00, 8'd21, "R4 stable within group");
        wait_irq(3 * PG);
        get(8'h00, 8'd22, "R3 next group advances");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_tick;
        t_plain;
        t_offsets;
        t_ctrl;
        t_bad_index;
        t_seconds;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule